// File: doc/BRIEF.md
# Framed Serial Control and Status Port

This block is the slave side of a four-wire serial link for a multi-channel half-bridge power stage. A host frames each transfer by pulling chip-select low and then clocks in a 16-bit control word, least significant bit first. In the same frame the block returns a 16-bit status word, also least significant bit first.

The block samples the serial pins with its own fast system clock and finds their edges there. The system clock must run at least eight times faster than the serial clock. A received control word is applied only when chip-select rises after exactly sixteen serial clock falls. Any other frame length is thrown away. The status word is a snapshot of a parallel word from the protection logic, taken at the moment chip-select falls.

The held control register drives per-switch enables for each channel, an open-load test disable, a short-timer select and a run/standby flag. A one-cycle status-clear pulse goes to the protection logic. The serial data-out pin gets a separate enable so that the pad can tri-state it and let several devices share one return line.

Top module: `serial_ctl_port`

## Requirements
- R1: After reset the control outputs read run=1, long_delay=1, openload_off=1, all switch enables 0. Data-out enable and status-clear are 0.
- R2: `sdo_oe_o` is high while a frame is open (chip-select low, as seen after synchronization) and low otherwise.
- R3: The parallel status word is captured when chip-select falls, and its bit 0 is on `sdo_d_o` as soon as the enable rises. Changes to `status_i` later in the frame do not alter the returned word.
- R4: Status leaves LSB first. The serial clock's first rising edge in a frame leaves bit 0 on the line. Each later rising edge advances by one bit, so bit k is on the line while the host sees falling edge k+1.
- R5: `sdi_i` is sampled on falling serial clock edges, LSB first. Control word layout: bit 0 = status clear command; bit 2k+1 = low-side enable of channel k, and bit 2k+2 = high-side enable of channel k (k = 0..5); bit 13 = open-load test off when 1; bit 14 = long short-circuit delay when 1; bit 15 = run (0 = standby).
- R6: The control outputs change only at a chip-select rise that closes a frame of exactly 16 falling serial clock edges. Frames of 15, 17 or 0 edges change nothing.
- R7: A valid frame whose bit 0 is 1 raises `status_clr_o` for exactly one system clock cycle. Other frames never raise it.
- R8: A bare chip-select pulse, with no serial clocks, shows status bit 0 on `sdo_d_o` and leaves every control output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n_i | input | 1 | Serial chip-select, active low |
| sclk_i | input | 1 | Serial clock |
| sdi_i | input | 1 | Serial data in |
| sdo_d_o | output | 1 | Serial data out value |
| sdo_oe_o | output | 1 | Serial data out drive enable for the pad |
| status_i | input | 16 | Parallel status word from protection logic |
| low_en_o | output | 6 | Low-side switch enables, one per channel |
| high_en_o | output | 6 | High-side switch enables, one per channel |
| openload_off_o | output | 1 | Open-load test disabled when 1 |
| long_delay_o | output | 1 | Long short-circuit delay selected when 1 |
| run_o | output | 1 | Software run flag, 0 = standby |
| status_clr_o | output | 1 | One-cycle clear of latched fault status |

## Verification
The bench uses the defaults: six channels, which give a 16-bit word, and two synchronizer stages. With these the full word layout and the edge-detection latency of three system cycles can be checked directly. The serial clock half-period is six system cycles, so each data-out shift settles well before the host samples it. Short, long and empty frames all fit inside a few hundred cycles.

// File: rtl/serial_ctl_port.sv
module serial_ctl_port #(
  parameter int CHANNELS    = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n_i,
  input  logic                    sclk_i,
  input  logic                    sdi_i,
  output logic                    sdo_d_o,
  output logic                    sdo_oe_o,
  input  logic [2*CHANNELS+3:0]   status_i,
  output logic [CHANNELS-1:0]     low_en_o,
  output logic [CHANNELS-1:0]     high_en_o,
  output logic                    openload_off_o,
  output logic                    long_delay_o,
  output logic                    run_o,
  output logic                    status_clr_o
);

  localparam int W     = 2*CHANNELS + 4;
  localparam int CNT_W = $clog2(W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(W + 1);
  localparam logic [W-1:1] CTL_RST = {3'b111, {(W-4){1'b0}}};

  logic [SYNC_STAGES-1:0] cs_sync, ck_sync, di_sync;
  logic cs_s, ck_s, di_s, cs_q, ck_q;
  logic active;
  logic [CNT_W-1:0] cnt;
  logic [W-1:0] shin, shout;
  logic [W-1:1] ctl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_sync <= '1;
      ck_sync <= '0;
      di_sync <= '0;
      cs_q    <= 1'b1;
      ck_q    <= 1'b0;
    end else begin
      cs_sync <= {cs_sync[SYNC_STAGES-2:0], cs_n_i};
      ck_sync <= {ck_sync[SYNC_STAGES-2:0], sclk_i};
      di_sync <= {di_sync[SYNC_STAGES-2:0], sdi_i};
      cs_q    <= cs_s;
      ck_q    <= ck_s;
    end
  end

  assign cs_s = cs_sync[SYNC_STAGES-1];
  assign ck_s = ck_sync[SYNC_STAGES-1];
  assign di_s = di_sync[SYNC_STAGES-1];

  wire cs_fall = cs_q & ~cs_s;
  wire cs_rise = ~cs_q & cs_s;
  wire ck_fall = active & ck_q & ~ck_s;
  wire ck_rise = active & ~ck_q & ck_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active       <= 1'b0;
      cnt          <= '0;
      shin         <= '0;
      shout        <= '0;
      ctl_q        <= CTL_RST;
      status_clr_o <= 1'b0;
    end else begin
      status_clr_o <= 1'b0;
      if (cs_fall) begin
        active <= 1'b1;
        cnt    <= '0;
        shout  <= status_i;
      end else if (cs_rise) begin
        active <= 1'b0;
        if (active && cnt == CNT_FULL) begin
          ctl_q        <= shin[W-1:1];
          status_clr_o <= shin[0];
        end
      end else begin
        if (ck_fall) begin
          shin <= {di_s, shin[W-1:1]};
          if (cnt != CNT_OVER) cnt <= cnt + 1'b1;
        end
        if (ck_rise && cnt != '0) shout <= {1'b0, shout[W-1:1]};
      end
    end
  end

  assign sdo_d_o  = shout[0];
  assign sdo_oe_o = active;

  for (genvar k = 0; k < CHANNELS; k++) begin : g_ch
    assign low_en_o[k]  = ctl_q[2*k+1];
    assign high_en_o[k] = ctl_q[2*k+2];
  end
  assign openload_off_o = ctl_q[W-3];
  assign long_delay_o   = ctl_q[W-2];
  assign run_o          = ctl_q[W-1];

  assert_ctl_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_rise |=> $stable(ctl_q));

  assert_cnt_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_OVER);

  assert_clr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_o |=> !status_clr_o);

  assert_clr_origin_R7: assert property (@(posedge clk) disable iff (!rst_n)
    status_clr_o |-> $past(cs_rise));

  assert_first_bit_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sdo_oe_o) |-> sdo_d_o == $past(status_i[0]));

  assert_oe_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && cs_q) |-> !sdo_oe_o);

endmodule

// File: tb/test_serial_ctl_port.sv
module test_serial_ctl_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int NV = 5;
  localparam logic [31:0] VEC [NV] = '{
    {16'hA5A4, 16'h1234},
    {16'h5A5A, 16'hFFFF},
    {16'h0FFF, 16'h8001},
    {16'hFFFE, 16'h0000},
    {16'h6001, 16'hC3A5}
  };

  logic clk = 0, rst_n = 0, cs_n = 1, sclk = 0, sdi = 0;
  logic [15:0] status = '0;
  logic sdo_d, sdo_oe, olo, lng, run, clr;
  logic [5:0] lo_en, hi_en;
  int checks = 0, fails = 0, clr_seen = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_ctl_port i_serial_ctl_port (
    .clk(clk), .rst_n(rst_n), .cs_n_i(cs_n), .sclk_i(sclk), .sdi_i(sdi),
    .sdo_d_o(sdo_d), .sdo_oe_o(sdo_oe), .status_i(status),
    .low_en_o(lo_en), .high_en_o(hi_en), .openload_off_o(olo),
    .long_delay_o(lng), .run_o(run), .status_clr_o(clr));

  always @(negedge clk) if (clr) clr_seen++;

  function automatic logic [15:0] outs();
    logic [15:0] w = '0;
    for (int k = 0; k < 6; k++) begin
      w[2*k+1] = lo_en[k];
      w[2*k+2] = hi_en[k];
    end
    w[13] = olo; w[14] = lng; w[15] = run;
    return w;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic frame(input logic [15:0] word, input logic [15:0] st, input int nclk,
                       output logic [15:0] got);
    got = '0;
    @(posedge clk) #1; status = st; cs_n = 0;
    repeat (5) @(posedge clk);
    #1 status = ~st;
    @(negedge clk) chk(sdo_oe == 1'b1, "R2 oe during frame", {31'b0, sdo_oe}, 1);
    for (int i = 0; i < nclk; i++) begin
      @(posedge clk) #1; sdi = (i < 16) ? word[i] : 1'b0; sclk = 1;
      repeat (HALF) @(posedge clk);
      @(negedge clk) if (i < 16) got[i] = sdo_d;
      @(posedge clk) #1; sclk = 0;
      repeat (HALF) @(posedge clk);
    end
    @(posedge clk) #1; cs_n = 1;
    repeat (8) @(posedge clk);
    @(negedge clk) chk(sdo_oe == 1'b0, "R2 oe after frame", {31'b0, sdo_oe}, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] got, prev;
    int c0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (2) @(negedge clk);
    // R1 reset state
    chk(outs() == 16'hE000, "R1 control reset", {16'b0, outs()}, 32'hE000);
    chk(sdo_oe == 1'b0, "R1 oe reset", {31'b0, sdo_oe}, 0);
    chk(clr == 1'b0, "R1 clr reset", {31'b0, clr}, 0);

    for (int v = 0; v < NV; v++) begin
      c0 = clr_seen;
      frame(VEC[v][31:16], VEC[v][15:0], 16, got);
      // R3 R4 snapshot returned LSB first
      chk(got == VEC[v][15:0], "R3 R4 status word", {16'b0, got}, {16'b0, VEC[v][15:0]});
      // R5 field decode
      chk(outs() == {VEC[v][31:17], 1'b0}, "R5 control fields", {16'b0, outs()}, {16'b0, VEC[v][31:17], 1'b0});
      // R7 clear pulse count
      chk(clr_seen - c0 == int'(VEC[v][16]), "R7 clear pulse", clr_seen - c0, VEC[v][16]);
    end

    prev = outs();
    c0 = clr_seen;
    frame(16'h1FFF, 16'h00F0, 15, got);
    chk(outs() == prev, "R6 short frame ignored", {16'b0, outs()}, {16'b0, prev});
    chk(clr_seen == c0, "R7 no clear on short frame", clr_seen, c0);

    frame(16'hFFFF, 16'h00F0, 17, got);
    chk(outs() == prev, "R6 long frame ignored", {16'b0, outs()}, {16'b0, prev});
    chk(clr_seen == c0, "R7 no clear on long frame", clr_seen, c0);

    // R8 bare chip-select pulse reads bit 0
    @(posedge clk) #1; status = 16'h0001; cs_n = 0;
    repeat (5) @(posedge clk);
    #1 status = 16'h0000;
    @(negedge clk);
    chk(sdo_oe == 1'b1, "R8 oe on pulse", {31'b0, sdo_oe}, 1);
    chk(sdo_d == 1'b1, "R8 bit0 on pulse", {31'b0, sdo_d}, 1);
    @(posedge clk) #1; cs_n = 1;
    repeat (8) @(posedge clk);
    @(negedge clk);
    chk(outs() == prev, "R8 R6 pulse leaves control", {16'b0, outs()}, {16'b0, prev});
    chk(clr_seen == c0, "R8 no clear on pulse", clr_seen, c0);
    chk(sdo_oe == 1'b0, "R2 oe after pulse", {31'b0, sdo_oe}, 0);

    // R3 snapshot with bit 0 low
    frame(16'h8000, 16'hFFFE, 16, got);
    chk(got == 16'hFFFE, "R3 snapshot bit0 low", {16'b0, got}, 32'hFFFE);
    chk(outs() == 16'h8000, "R5 run only", {16'b0, outs()}, 32'h8000);

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule